// File: doc/BRIEF.md
# Four-Stage Pipeline Sequencer with Stage-2 Jump Redirect

This block sequences instruction fetch through a four-stage in-order pipeline and decides, every cycle, where the next fetch comes from and which instructions in flight survive. Instructions are read from a small synchronous instruction store that is written through a load port. A fetched word moves from stage 1 to stage 4 in lockstep, one stage per clock, with no stalls. Condition tests against the Z and C flags, flag and register updates, and ordinary branches are all resolved in stage 4. A taken branch there costs three squashed slots, unless its delayed form lets those slots run.

An always-taken jump to an immediate address gets a shortcut. It is recognised in stage 2 and steers the very next fetch to its target, so it costs at most one squashed slot. Its delayed form costs none. When that jump later reaches stage 4 it does nothing. If an older branch in stage 3 or 4 overrides it, the older branch's target wins and everything fetched behind the early jump is squashed. A retire port reports the address, word and outcome of every slot that leaves stage 4.

Instruction layout (32 bits): condition in [31:28], opcode in [27:24], register select in [17:16], immediate in [15:0]. The jump target is the low address-width bits of the immediate. Opcodes: 0 no-op, 1 set flags, 2 load register, 3 jump immediate, 4 delayed jump immediate, 5 jump to register, 6 delayed jump to register. All others act as no-ops.

Top module: `pipe4_ctrl`

The fetch sequencer is a two-state machine. It is in BOOT during and right after reset, and fetches address 0 from there. It moves to RUN unconditionally on the first clock after reset and stays there. In RUN, the fetch source is picked with this priority: LATE (stage-4 redirect), then EARLY (stage-2 redirect), then SEQ (last fetch address plus one).

## Requirements
- R1: While reset is held, every stage reports status 00 (empty) and the retire port is idle. After release, the first instruction retired comes from address 0.
- R2: An instruction executes only when bit {Z,C} of its condition field [31:28] is 1, so 0000 never executes and 1111 always executes. A non-executing instruction retires with status 10 and changes no PC, flag or register.
- R3: A taken jump that is not an early jump (opcode 3 with a condition other than 1111, or opcode 5) redirects fetch from stage 4. The three younger slots retire with status 11, and the target is the next slot to retire.
- R4: The delayed late jumps (opcode 4 with a condition other than 1111, or opcode 6) let the three younger slots execute before the target.
- R5: Opcode 2 writes imm[AW-1:0] into the register chosen by [17:16] in stage 4. Opcodes 5 and 6 jump to the value of the register chosen by [17:16].
- R6: Opcode 3 with condition 1111 is taken in stage 2. The next fetch comes from its target, and only the one slot fetched behind it is squashed.
- R7: Opcode 4 with condition 1111 is taken in stage 2, and the slot fetched behind it executes.
- R8: An early jump that reaches stage 4 retires as executed and causes no second redirect.
- R9: When a stage-4 redirect and a stage-2 early jump fall in the same cycle, the stage-4 target is fetched and the early jump retires squashed.
- R10: When an older branch one stage ahead is taken in the cycle after an early jump redirected fetch, the slot fetched from the early target retires squashed and the older branch's target follows.
- R11: Opcode 1 sets Z to imm[1] and C to imm[0] in stage 4, and only when it executes.
- R12: Status codes on the stage and retire ports are 00 empty, 01 executed/live, 10 condition false, 11 squashed. Every slot leaving stage 4 is reported with its address and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | AW | Instruction store write address |
| imem_wdata | input | 32 | Instruction store write data |
| ret_valid | output | 1 | A slot is leaving stage 4 this cycle |
| ret_pc | output | AW | Address of the retiring slot |
| ret_instr | output | 32 | Word of the retiring slot |
| ret_status | output | 2 | Outcome of the retiring slot |
| stage_status | output | 8 | Status of stages 1 to 4, stage 1 in [1:0] |
| flag_z | output | 1 | Z flag |
| flag_c | output | 1 | C flag |

## Verification
The stage-4 redirect and the stage-2 early redirect can fall in the same cycle. The bench provokes this by placing an always-taken immediate jump two slots behind a taken conditional jump. The retire trace must show the early jump squashed, the early target never fetched, and the conditional jump's target following. A second program fragment places the early jump one slot behind instead, so the early redirect happens first and is then overridden. Here the trace must show the slot fetched from the early target as squashed.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

    localparam int IW  = 32;
    localparam int RSW = 2;
    localparam int NREG = 1 << RSW;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'b00,
        ST_EXEC   = 2'b01,
        ST_CFALSE = 2'b10,
        ST_SQUASH = 2'b11
    } stat_e;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_SETF  = 4'd1;
    localparam logic [3:0] OP_LDI   = 4'd2;
    localparam logic [3:0] OP_JMP   = 4'd3;
    localparam logic [3:0] OP_JMPD  = 4'd4;
    localparam logic [3:0] OP_JMPR  = 4'd5;
    localparam logic [3:0] OP_JMPRD = 4'd6;

    localparam logic [3:0] COND_ALWAYS = 4'hF;

    function automatic logic cond_pass(input logic [3:0] cnd, input logic z, input logic c);
        return cnd[{z, c}];
    endfunction

    function automatic logic is_early(input logic [3:0] cnd, input logic [3:0] op);
        return (cnd == COND_ALWAYS) && ((op == OP_JMP) || (op == OP_JMPD));
    endfunction

endpackage

// File: rtl/pipe4_fetch.sv
module pipe4_fetch
    import pipe4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [IW-1:0]     wdata,
    input  logic              late_take,
    input  logic [AW-1:0]     late_tgt,
    input  logic              early_take,
    input  logic [AW-1:0]     early_tgt,
    output logic              s1_occ,
    output logic [AW-1:0]     s1_pc,
    output logic [IW-1:0]     s1_ins
);
    localparam int DEPTH = 1 << AW;

    typedef enum logic {FS_BOOT, FS_RUN} fstate_e;
    typedef enum logic [1:0] {SRC_BOOT, SRC_SEQ, SRC_EARLY, SRC_LATE} fsrc_e;

    fstate_e        state_q, state_d;
    fsrc_e          src;
    logic [AW-1:0]  last_q;
    logic [AW-1:0]  faddr;
    logic [IW-1:0]  mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_BOOT: state_d = FS_RUN;
            FS_RUN:  state_d = FS_RUN;
        endcase
    end

    always_comb begin
        if (state_q == FS_BOOT) src = SRC_BOOT;
        else if (late_take)     src = SRC_LATE;
        else if (early_take)    src = SRC_EARLY;
        else                    src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_BOOT:  faddr = '0;
            SRC_LATE:  faddr = late_tgt;
            SRC_EARLY: faddr = early_tgt;
            SRC_SEQ:   faddr = last_q + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_occ <= 1'b0;
            s1_pc  <= '0;
            s1_ins <= '0;
            last_q <= '0;
        end else begin
            s1_occ <= 1'b1;
            s1_pc  <= faddr;
            s1_ins <= mem[faddr];
            last_q <= faddr;
        end
    end

endmodule

// File: rtl/pipe4_early.sv
module pipe4_early
    import pipe4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          s2_live,
    input  logic          blocked,
    input  logic [3:0]    cnd,
    input  logic [3:0]    op,
    input  logic [AW-1:0] imm,
    output logic          early_take,
    output logic          early_cancel,
    output logic [AW-1:0] early_tgt
);
    always_comb begin
        early_take   = s2_live && !blocked && is_early(cnd, op);
        early_cancel = early_take && (op == OP_JMP);
        early_tgt    = imm;
    end
endmodule

// File: rtl/pipe4_exec.sv
module pipe4_exec
    import pipe4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           occ,
    input  logic           sq,
    input  logic [3:0]     cnd,
    input  logic [3:0]     op,
    input  logic [RSW-1:0] rsel,
    input  logic [AW-1:0]  imm,
    output logic [1:0]     status,
    output logic           late_take,
    output logic           late_cancel,
    output logic [AW-1:0]  late_tgt,
    output logic           flag_z,
    output logic           flag_c
);
    logic          pass;
    logic          exec;
    stat_e         st;
    logic [AW-1:0] rf [NREG];

    always_comb begin
        pass = cond_pass(cnd, flag_z, flag_c);
        exec = occ && !sq && pass;
        if (!occ)      st = ST_EMPTY;
        else if (sq)   st = ST_SQUASH;
        else if (pass) st = ST_EXEC;
        else           st = ST_CFALSE;
        status = st;
    end

    always_comb begin
        late_take   = 1'b0;
        late_cancel = 1'b0;
        late_tgt    = imm;
        unique case (op)
            OP_JMP: begin
                late_take   = exec && !is_early(cnd, op);
                late_cancel = late_take;
            end
            OP_JMPD: begin
                late_take   = exec && !is_early(cnd, op);
            end
            OP_JMPR: begin
                late_take   = exec;
                late_cancel = exec;
                late_tgt    = rf[rsel];
            end
            OP_JMPRD: begin
                late_take   = exec;
                late_tgt    = rf[rsel];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (exec && op == OP_SETF) begin
            flag_z <= imm[1];
            flag_c <= imm[0];
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_rf
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rf[g] <= '0;
                else if (exec && op == OP_LDI && rsel == RSW'(g))
                    rf[g] <= imm;
            end
        end
    endgenerate

endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
    import pipe4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          imem_we,
    input  logic [AW-1:0] imem_waddr,
    input  logic [31:0]   imem_wdata,
    output logic          ret_valid,
    output logic [AW-1:0] ret_pc,
    output logic [31:0]   ret_instr,
    output logic [1:0]    ret_status,
    output logic [7:0]    stage_status,
    output logic          flag_z,
    output logic          flag_c
);
    logic          s1_occ;
    logic [AW-1:0] s1_pc;
    logic [IW-1:0] s1_ins;
    logic          s2_occ, s3_occ, s4_occ;
    logic          s2_sq,  s3_sq,  s4_sq;
    logic [AW-1:0] s2_pc,  s3_pc,  s4_pc;
    logic [IW-1:0] s2_ins, s3_ins, s4_ins;

    logic          late_take, late_cancel, early_take, early_cancel;
    logic [AW-1:0] late_tgt, early_tgt;
    logic [1:0]    s4_status;

    pipe4_fetch #(.AW(AW)) fetch_i (
        .clk(clk), .rst_n(rst_n),
        .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
        .late_take(late_take), .late_tgt(late_tgt),
        .early_take(early_take), .early_tgt(early_tgt),
        .s1_occ(s1_occ), .s1_pc(s1_pc), .s1_ins(s1_ins)
    );

    pipe4_early #(.AW(AW)) early_i (
        .s2_live(s2_occ && !s2_sq),
        .blocked(late_take),
        .cnd(s2_ins[31:28]), .op(s2_ins[27:24]), .imm(s2_ins[AW-1:0]),
        .early_take(early_take), .early_cancel(early_cancel), .early_tgt(early_tgt)
    );

    pipe4_exec #(.AW(AW)) exec_i (
        .clk(clk), .rst_n(rst_n),
        .occ(s4_occ), .sq(s4_sq),
        .cnd(s4_ins[31:28]), .op(s4_ins[27:24]),
        .rsel(s4_ins[16 +: RSW]), .imm(s4_ins[AW-1:0]),
        .status(s4_status),
        .late_take(late_take), .late_cancel(late_cancel), .late_tgt(late_tgt),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_occ <= 1'b0; s3_occ <= 1'b0; s4_occ <= 1'b0;
            s2_sq  <= 1'b0; s3_sq  <= 1'b0; s4_sq  <= 1'b0;
            s2_pc  <= '0;   s3_pc  <= '0;   s4_pc  <= '0;
            s2_ins <= '0;   s3_ins <= '0;   s4_ins <= '0;
        end else begin
            s2_occ <= s1_occ;
            s2_sq  <= late_cancel || early_cancel;
            s2_pc  <= s1_pc;
            s2_ins <= s1_ins;
            s3_occ <= s2_occ;
            s3_sq  <= s2_sq || late_cancel;
            s3_pc  <= s2_pc;
            s3_ins <= s2_ins;
            s4_occ <= s3_occ;
            s4_sq  <= s3_sq || late_cancel;
            s4_pc  <= s3_pc;
            s4_ins <= s3_ins;
        end
    end

    function automatic logic [1:0] mid_stat(input logic occ, input logic sq);
        if (!occ)    return ST_EMPTY;
        else if (sq) return ST_SQUASH;
        else         return ST_EXEC;
    endfunction

    always_comb begin
        stage_status[1:0] = mid_stat(s1_occ, 1'b0);
        stage_status[3:2] = mid_stat(s2_occ, s2_sq);
        stage_status[5:4] = mid_stat(s3_occ, s3_sq);
        stage_status[7:6] = s4_status;
        ret_valid  = s4_occ;
        ret_pc     = s4_pc;
        ret_instr  = s4_ins;
        ret_status = s4_status;
    end

endmodule

// File: rtl/pipe4_chk.sv
module pipe4_chk
    import pipe4_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          late_take,
    input logic          late_cancel,
    input logic [AW-1:0] late_tgt,
    input logic          early_take,
    input logic          early_cancel,
    input logic [AW-1:0] early_tgt,
    input logic [AW-1:0] s1_pc,
    input logic          s2_sq,
    input logic          s3_sq,
    input logic          s4_sq,
    input logic          ret_valid,
    input logic [1:0]    ret_status,
    input logic [31:0]   ret_instr,
    input logic          flag_z,
    input logic          flag_c
);
    AST_LATE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        late_take |=> (s1_pc == $past(late_tgt))); // R3

    AST_LATE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        late_cancel |=> (s2_sq && s3_sq && s4_sq)); // R3

    AST_EARLY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        early_take |=> (s1_pc == $past(early_tgt))); // R6

    AST_EARLY_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        early_cancel |=> s2_sq); // R6

    AST_EARLY_NOOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_early(ret_instr[31:28], ret_instr[27:24])) |-> !late_take); // R8

    AST_NO_REDIRECT_UNLESS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_status != ST_EXEC) |-> !late_take); // R2

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && ret_status == ST_EXEC) |=> $stable({flag_z, flag_c})); // R11

    AST_NEVER_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_instr[31:28] == 4'h0) |-> (ret_status != ST_EXEC)); // R2

endmodule

bind pipe4_ctrl pipe4_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .late_take(late_take), .late_cancel(late_cancel), .late_tgt(late_tgt),
    .early_take(early_take), .early_cancel(early_cancel), .early_tgt(early_tgt),
    .s1_pc(s1_pc), .s2_sq(s2_sq), .s3_sq(s3_sq), .s4_sq(s4_sq),
    .ret_valid(ret_valid), .ret_status(ret_status), .ret_instr(ret_instr),
    .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/pipe4_ctrl_tb_top.sv
module pipe4_ctrl_tb_top;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    localparam logic [1:0] E = 2'b01, CF = 2'b10, SQ = 2'b11;
    localparam logic [3:0] AL = 4'hF, NV = 4'h0, IFZ = 4'b1100, IFNZ = 4'b0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [31:0]   imem_wdata = '0;
    logic          ret_valid;
    logic [AW-1:0] ret_pc;
    logic [31:0]   ret_instr;
    logic [1:0]    ret_status;
    logic [7:0]    stage_status;
    logic          flag_z, flag_c;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] prog [DEPTH];
    logic [AW+1:0] exp_q [$];

    always #2 clk = ~clk;

    pipe4_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_instr(ret_instr),
        .ret_status(ret_status), .stage_status(stage_status),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic logic [31:0] enc(input logic [3:0] cnd, input logic [3:0] op,
                                        input logic [1:0] rs, input logic [15:0] imm);
        return {cnd, op, 6'b0, rs, imm};
    endfunction

    task automatic check(input bit ok, input string req, input string got, input string want);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", req, got, want);
        end
    endtask

    task automatic span(input int lo, input int hi, input logic [1:0] st);
        for (int a = lo; a <= hi; a++) exp_q.push_back({AW'(a), st});
    endtask

    // monitor: pops expected retire items and compares
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ret_valid && !done) begin
                logic [AW+1:0] it;
                it = exp_q.pop_front();
                // R3 R4 R6 R7 R8 R9 R10 R12: retire trace order and outcome
                check(ret_pc == it[AW+1:2] && ret_status == it[1:0] &&
                      ret_instr == prog[it[AW+1:2]], "R12 trace",
                      $sformatf("pc=%0d st=%0d w=%h", ret_pc, ret_status, ret_instr),
                      $sformatf("pc=%0d st=%0d w=%h", it[AW+1:2], it[1:0], prog[it[AW+1:2]]));
                if (exp_q.size() == 0) done = 1'b1;
            end
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) prog[a] = '0;
        prog[0]  = enc(AL,   4'd1, 2'd0, 16'd0);   // Z=0 C=0
        prog[1]  = enc(NV,   4'd3, 2'd0, 16'd40);  // R2 never
        prog[2]  = enc(IFNZ, 4'd3, 2'd0, 16'd6);   // R3 late
        prog[6]  = enc(AL,   4'd3, 2'd0, 16'd10);  // R6 early cancel
        prog[10] = enc(AL,   4'd4, 2'd0, 16'd14);  // R7 early delayed
        prog[11] = enc(AL,   4'd0, 2'd0, 16'd0);
        prog[14] = enc(AL,   4'd2, 2'd1, 16'd20);  // R5 r1=20
        prog[15] = enc(AL,   4'd5, 2'd1, 16'd0);   // R5 jump r1
        prog[20] = enc(AL,   4'd1, 2'd0, 16'd3);   // Z=1 C=1
        prog[21] = enc(IFZ,  4'd4, 2'd0, 16'd30);  // R4 delayed late
        prog[22] = enc(AL,   4'd0, 2'd0, 16'd0);
        prog[23] = enc(AL,   4'd0, 2'd0, 16'd0);
        prog[24] = enc(AL,   4'd0, 2'd0, 16'd0);
        prog[30] = enc(IFNZ, 4'd3, 2'd0, 16'd50);  // R2 cond false
        prog[31] = enc(IFZ,  4'd3, 2'd0, 16'd36);  // R9 older
        prog[32] = enc(AL,   4'd0, 2'd0, 16'd0);
        prog[33] = enc(AL,   4'd3, 2'd0, 16'd45);  // R9 early same cycle
        prog[36] = enc(IFZ,  4'd3, 2'd0, 16'd40);  // R10 older
        prog[37] = enc(AL,   4'd3, 2'd0, 16'd50);  // R10 early overridden
        prog[40] = enc(AL,   4'd1, 2'd0, 16'd1);   // R11 Z=0 C=1
        prog[41] = enc(NV,   4'd1, 2'd0, 16'd2);   // R11 not executed
        prog[42] = enc(IFNZ, 4'd3, 2'd0, 16'd46);
        prog[46] = enc(AL,   4'd3, 2'd0, 16'd46);  // R8 self loop

        span(0, 0, E);   span(1, 1, CF);  span(2, 2, E);   span(3, 5, SQ);
        span(6, 6, E);   span(7, 7, SQ);  span(10, 11, E);
        span(14, 15, E); span(16, 18, SQ); span(20, 24, E);
        span(30, 30, CF); span(31, 31, E); span(32, 34, SQ);
        span(36, 36, E); span(37, 38, SQ); span(50, 50, SQ);
        span(40, 40, E); span(41, 41, CF); span(42, 42, E); span(43, 45, SQ);
        for (int k = 0; k < 4; k++) begin
            span(46, 46, E); span(47, 47, SQ);
        end

        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = AW'(a); imem_wdata = prog[a];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(ret_valid == 1'b0, "R1 retire idle", $sformatf("%0b", ret_valid), "0");
        check(stage_status == 8'h00, "R1 stages empty",
              $sformatf("%h", stage_status), "00");
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 5000 && !done; cyc++) @(negedge clk);
        check(done, "R12 watchdog", "timeout", "trace complete");
        // R11: final flags after executed and non-executed flag writes
        check(flag_z == 1'b0, "R11 flag Z", $sformatf("%0b", flag_z), "0");
        check(flag_c == 1'b1, "R11 flag C", $sformatf("%0b", flag_c), "1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule